// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a 24-bit down-counter that produces a regular time base. Software sets up three registers through a simple synchronous register bus: a control/status word, a reload value and the live count. While running, the counter steps down once per tick. A tick is either every core clock cycle or every rising edge of a slower reference clock. The reference clock is brought into the core domain by a two-stage synchroniser and then edge-detected. When the count moves from 1 to 0, a sticky zero flag is set and an optional one-cycle pend pulse is sent to the interrupt logic. On the next tick the counter reloads, so it keeps running until it is disabled.

The zero flag clears when the control word is read. A read marked as coming from a debugger clears the flag only while the master-type input is low. The register bus has no back-pressure: it accepts one access in every cycle where `bus_en` is high. Read data is combinational and is valid in the same cycle as the request. Any side effect of an access takes place at the clock edge that ends that cycle. The pend pulse and the flag are plain status pins, not streams.

Top module: `tick_timer`

## Requirements
- R1: Word index 0 is the control word, with enable at bit 0, interrupt-enable at bit 1, source select at bit 2 (1 = core clock, 0 = reference) and the zero flag at bit 16. All other bits read 0 and writes to them are ignored. After reset the control word reads 0 when a reference clock is present.
- R2: Word index 1 holds a 24-bit reload value and word index 2 returns the 24-bit current count. Bits above bit 23 read 0, index 3 reads 0, and the count and reload both reset to 0.
- R3: While enabled, each tick takes a count of 0 to the reload value and any other count down by one. With reload value N, zero is reached every N+1 ticks.
- R4: While enable is 0, the count holds its value.
- R5: The tick that takes the count from 1 to 0 sets the zero flag, which then stays set until it is cleared.
- R6: With interrupt-enable at 1, `tick_pend` is high for exactly one cycle: the cycle after the edge at which the count became 0. With interrupt-enable at 0, `tick_pend` stays low.
- R7: A read of the control word with `bus_dbg` low returns the flag and then clears it.
- R8: A read of the control word with `bus_dbg` high leaves the flag set when `dbg_master_type` is 1, and clears it when `dbg_master_type` is 0.
- R9: With source select at 1, every core cycle is a tick. With source select at 0, the only ticks are rising edges of `ref_clk`, each counted once and taking effect by the third core edge after the rise.
- R10: With HAS_REF = 0, the source-select bit reads 1 from reset onward, and writes to it are ignored.
- R11: A write of any data to index 2 sets the count to 0 and clears the flag, and no pend pulse results from it.
- R12: With a reload value of 0, the count stays at 0, the flag is never set and no pend pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index (0 control, 1 reload, 2 current) |
| bus_wdata | input | 32 | Write data |
| bus_dbg | input | 1 | Access comes from a debugger |
| dbg_master_type | input | 1 | Debugger master type; 1 keeps the flag on debugger reads |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| ref_clk | input | 1 | Slower reference clock, asynchronous to clk |
| tick_pend | output | 1 | One-cycle pend pulse on reaching zero |

## Verification
The reference-clock path is the hardest part to pin down from the ports. A rising edge of `ref_clk` passes through two synchroniser flops and an edge register before the count moves, so any check made too early or too late sees the wrong value. The bench drives the reference clock from its own task at a ratio of six core cycles per period and aligns each change to a core falling edge. It then reads the count five cycles after every rise. This is after the third-edge update and before the next rise has any effect, so the check can follow a full load, step down and zero sequence edge by edge. The debugger-read cases are reached in a similar way. The bench first sets the flag and then stops the counter, so that no new zero event can mask whether a given read cleared the flag.

// File: rtl/tick_pkg.sv
`timescale 1ns/1ps
package tick_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] IDX_CTRL    = 2'd0;
  localparam logic [ADDR_W-1:0] IDX_RELOAD  = 2'd1;
  localparam logic [ADDR_W-1:0] IDX_CURRENT = 2'd2;

  localparam int BIT_EN   = 0;
  localparam int BIT_IRQ  = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;

  typedef struct packed {
    logic src;   // 1 = core clock ticks
    logic irq;   // raise pend on zero
    logic en;    // counter running
  } tick_ctrl_t;
endpackage

// File: rtl/tick_ref_sync.sv
`timescale 1ns/1ps
// Brings the reference clock into the core domain and marks its rising edges.
module tick_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], ref_in};
  end

  // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its delayed copy
  assign ref_rise = chain_q[LAST-1] & ~chain_q[LAST];

  // R9: one rising edge yields exactly one tick
  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !ref_rise);
endmodule

// File: rtl/tick_down_counter.sv
`timescale 1ns/1ps
// Reloading down-counter; reports the 1 -> 0 transition as a strobe.
module tick_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             zero_hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             advance;

  assign advance  = run & step & ~clear;
  assign zero_hit = advance & (count_q == ONE);
  assign count    = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (advance) begin
      if (count_q == '0) count_q <= reload;
      else               count_q <= count_q - ONE;
    end
  end

  // R4: a stopped counter keeps its value
  a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(count_q));
  // R11: a clear lands on zero
  a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count_q == '0));
  // R3: a tick taken at zero picks up the reload value
  a_r3_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && count_q == '0) |=> (count_q == $past(reload)));
endmodule

// File: rtl/tick_regs.sv
`timescale 1ns/1ps
// Register decode, control bits, sticky zero flag and pend pulse.
module tick_regs
  import tick_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter bit HAS_REF = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_dbg,
  input  logic              dbg_master_type,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              zero_hit,
  output tick_ctrl_t        ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              count_clear,
  output logic              tick_pend
);
  logic wr_ctrl, wr_reload, rd_ctrl, rd_clears;
  logic en_q, irq_q, src_bit, flag_q, pend_q;
  logic [CNT_W-1:0] reload_q;
  logic [DATA_W-1:0] ctrl_word;
  logic unused_wdata_bits;

  assign unused_wdata_bits = ^bus_wdata;

  assign wr_ctrl     = bus_en & bus_we & (bus_addr == IDX_CTRL);
  assign wr_reload   = bus_en & bus_we & (bus_addr == IDX_RELOAD);
  assign count_clear = bus_en & bus_we & (bus_addr == IDX_CURRENT);
  assign rd_ctrl     = bus_en & ~bus_we & (bus_addr == IDX_CTRL);
  assign rd_clears   = rd_ctrl & (~bus_dbg | ~dbg_master_type);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      irq_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= bus_wdata[BIT_EN];
        irq_q <= bus_wdata[BIT_IRQ];
      end
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  generate
    if (HAS_REF) begin : g_src_reg
      logic src_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       src_q <= 1'b0;
        else if (wr_ctrl) src_q <= bus_wdata[BIT_SRC];
      end
      assign src_bit = src_q;
    end else begin : g_src_fixed
      assign src_bit = 1'b1;
    end
  endgenerate

  // Flag: a count write wins, then a new zero event, then a clearing read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (count_clear)    flag_q <= 1'b0;
      else if (zero_hit)  flag_q <= 1'b1;
      else if (rd_clears) flag_q <= 1'b0;
      pend_q <= zero_hit & irq_q;
    end
  end

  assign ctrl.en    = en_q;
  assign ctrl.irq   = irq_q;
  assign ctrl.src   = src_bit;
  assign reload     = reload_q;
  assign tick_pend  = pend_q;

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[BIT_EN]   = en_q;
    ctrl_word[BIT_IRQ]  = irq_q;
    ctrl_word[BIT_SRC]  = src_bit;
    ctrl_word[BIT_FLAG] = flag_q;
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        IDX_CTRL:    bus_rdata = ctrl_word;
        IDX_RELOAD:  bus_rdata = DATA_W'(reload_q);
        IDX_CURRENT: bus_rdata = DATA_W'(count);
        default:     bus_rdata = '0;
      endcase
    end
  end

  // R6: pend is a single-cycle pulse
  a_r6_pend_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pend |=> !tick_pend);
  // R5: a pend never appears without the flag
  a_r5_pend_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pend |-> flag_q);
  // R8: debugger read with master type 1 keeps the flag
  a_r8_dbg_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && bus_dbg && dbg_master_type && flag_q) |=> flag_q);
  // R7: software read clears the flag when no new zero arrives
  a_r7_sw_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !bus_dbg && !zero_hit) |=> !flag_q);
  // R11: a count write leaves the flag clear and raises no pend
  a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    count_clear |=> (!flag_q && !tick_pend));
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter bit HAS_REF     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_dbg,
  input  logic              dbg_master_type,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_clk,
  output logic              tick_pend
);
  tick_ctrl_t       ctrl;
  logic [CNT_W-1:0] reload, count;
  logic             count_clear, zero_hit, ref_rise, step;

  tick_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_clk),
    .ref_rise (ref_rise)
  );

  assign step = ctrl.src ? 1'b1 : ref_rise;

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl.en),
    .step     (step),
    .clear    (count_clear),
    .reload   (reload),
    .count    (count),
    .zero_hit (zero_hit)
  );

  tick_regs #(.CNT_W(CNT_W), .HAS_REF(HAS_REF)) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_en          (bus_en),
    .bus_we          (bus_we),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_dbg         (bus_dbg),
    .dbg_master_type (dbg_master_type),
    .bus_rdata       (bus_rdata),
    .count           (count),
    .zero_hit        (zero_hit),
    .ctrl            (ctrl),
    .reload          (reload),
    .count_clear     (count_clear),
    .tick_pend       (tick_pend)
  );
endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0, bus_dbg = 1'b0, mtype = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_nr;
  logic        ref_clk = 1'b0;
  logic        tick_pend, pend_nr;

  int checks = 0, fails = 0, pend_cnt = 0;
  bit done = 1'b0;
  logic [31:0] rd_main, rd_nr;

  always #2.5 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_dbg(bus_dbg),
    .dbg_master_type(mtype), .bus_rdata(rdata), .ref_clk(ref_clk),
    .tick_pend(tick_pend));

  tick_timer #(.HAS_REF(1'b0)) uut_nr (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_dbg(bus_dbg),
    .dbg_master_type(mtype), .bus_rdata(rdata_nr), .ref_clk(ref_clk),
    .tick_pend(pend_nr));

  always @(negedge clk) if (tick_pend) pend_cnt++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  // entered at a falling edge, returns at the next one
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_dbg = 1'b0;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input bit dbg, input bit mt);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_dbg = dbg; mtype = mt;
    #1;
    rd_main = rdata; rd_nr = rdata_nr;
    @(negedge clk);
    bus_en = 1'b0; bus_dbg = 1'b0; mtype = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(2'd0, 0, 0); expect_eq("R1 reset control", rd_main, 32'h0);
    expect_eq("R10 reset source fixed", rd_nr, 32'h4);
    rd(2'd1, 0, 0); expect_eq("R2 reset reload", rd_main, 32'h0);
    rd(2'd2, 0, 0); expect_eq("R2 reset count", rd_main, 32'h0);
    rd(2'd3, 0, 0); expect_eq("R2 index 3 zero", rd_main, 32'h0);
  endtask

  task automatic t_layout;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 0, 0); expect_eq("R2 reload 24 bits", rd_main, 32'h00FF_FFFF);
    wr(2'd0, 32'hFFFF_FFF8);
    rd(2'd0, 0, 0); expect_eq("R1 reserved ignored", rd_main, 32'h0);
    wr(2'd0, 32'h6);
    rd(2'd0, 0, 0); expect_eq("R1 irq/src bits", rd_main, 32'h6);
    wr(2'd0, 32'h0);
    rd(2'd0, 0, 0); expect_eq("R10 write src 0 ignored", rd_nr & 32'h7, 32'h4);
  endtask

  task automatic t_core_period;
    int gap = 0, guard = 0;
    wr(2'd1, 32'd4); wr(2'd2, 32'h0); wr(2'd0, 32'h7);
    while (!tick_pend && guard < 50) begin @(negedge clk); guard++; end
    check(tick_pend === 1'b1, "R6 pend seen", {31'd0, tick_pend}, 32'h1);
    @(negedge clk); gap = 1;
    expect_eq("R6 pend one cycle", {31'd0, tick_pend}, 32'h0);
    while (!tick_pend && gap < 50) begin @(negedge clk); gap++; end
    expect_eq("R3 R9 period reload+1", gap, 32'd5);
    wr(2'd0, 32'h6);
    rd(2'd2, 0, 0); begin
      logic [31:0] v1 = rd_main;
      idle(8);
      rd(2'd2, 0, 0); expect_eq("R4 halted count", rd_main, v1);
    end
    rd(2'd0, 0, 0); expect_eq("R5 R7 flag reads set", rd_main, 32'h0001_0006);
    rd(2'd0, 0, 0); expect_eq("R7 flag cleared by read", rd_main, 32'h6);
  endtask

  task automatic t_values_noirq;
    int p0;
    wr(2'd1, 32'd10); wr(2'd2, 32'h0);
    wr(2'd0, 32'h5);
    rd(2'd2, 0, 0); expect_eq("R3 not yet ticked", rd_main, 32'd0);
    rd(2'd2, 0, 0); expect_eq("R3 load on first tick", rd_main, 32'd10);
    idle(3);
    rd(2'd2, 0, 0); expect_eq("R3 counts down", rd_main, 32'd6);
    p0 = pend_cnt;
    idle(20);
    expect_eq("R6 no pend with irq off", pend_cnt - p0, 32'd0);
    wr(2'd0, 32'h4);
    rd(2'd0, 0, 0); expect_eq("R5 flag without irq", rd_main, 32'h0001_0004);
  endtask

  task automatic t_reload_zero;
    int p0 = pend_cnt;
    wr(2'd1, 32'd0); wr(2'd2, 32'h0); wr(2'd0, 32'h7);
    idle(20);
    rd(2'd2, 0, 0); expect_eq("R12 count stays zero", rd_main, 32'd0);
    rd(2'd0, 0, 0); expect_eq("R12 flag stays clear", rd_main, 32'h7);
    expect_eq("R12 no pend", pend_cnt - p0, 32'd0);
    wr(2'd0, 32'h4);
  endtask

  task automatic arm_flag;
    wr(2'd1, 32'd2); wr(2'd2, 32'h0); wr(2'd0, 32'h5);
    idle(10);
    wr(2'd0, 32'h4);
  endtask

  task automatic t_debugger;
    arm_flag();
    rd(2'd0, 1, 1); expect_eq("R8 dbg mt1 returns flag", rd_main, 32'h0001_0004);
    rd(2'd0, 1, 1); expect_eq("R8 dbg mt1 keeps flag", rd_main, 32'h0001_0004);
    rd(2'd0, 1, 0); expect_eq("R8 dbg mt0 returns flag", rd_main, 32'h0001_0004);
    rd(2'd0, 0, 0); expect_eq("R8 dbg mt0 cleared flag", rd_main, 32'h4);
  endtask

  task automatic t_count_write;
    int p0;
    arm_flag();
    wr(2'd0, 32'h6);
    p0 = pend_cnt;
    wr(2'd2, 32'h0000_0123);
    rd(2'd2, 0, 0); expect_eq("R11 count zeroed", rd_main, 32'h0);
    rd(2'd0, 0, 0); expect_eq("R11 flag cleared by write", rd_main, 32'h6);
    idle(3);
    expect_eq("R11 no pend from write", pend_cnt - p0, 32'd0);
  endtask

  task automatic t_refclk;
    wr(2'd1, 32'd5); wr(2'd2, 32'h0); wr(2'd0, 32'h1);
    idle(10);
    rd(2'd2, 0, 0); expect_eq("R9 no tick without ref edge", rd_main, 32'd0);
    for (int i = 1; i <= 6; i++) begin
      ref_clk = 1'b1; idle(3);
      ref_clk = 1'b0; idle(2);
      rd(2'd2, 0, 0);
      expect_eq($sformatf("R9 ref edge %0d", i), rd_main, (i == 1) ? 32'd5 : 32'(6 - i));
    end
    wr(2'd0, 32'h0);
    rd(2'd0, 0, 0); expect_eq("R5 R9 flag from ref ticks", rd_main, 32'h0001_0000);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_layout();
    t_core_period();
    t_values_noirq();
    t_reload_zero();
    t_debugger();
    t_count_write();
    t_refclk();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule